// File: doc/BRIEF.md
# Current-Mode PWM Gating Logic

This block is the synchronous gating core of a fixed-frequency, peak-current-mode switching controller. A sawtooth counter takes the place of the timing capacitor. Each oscillator cycle has a charge phase and a discharge phase, and the gate drive is blanked for the whole discharge phase. A toggle stage turns off every second cycle, so the gate switches at half the oscillator rate. This caps the duty cycle at 50%, and the length of the discharge phase sets how far the deadtime rises above that.

Conduction begins when a cycle starts, because a set/reset latch is set at that point. An external peak-current comparator ends conduction by asserting a trip strobe, which resets the latch. The latch cannot set again until the next cycle start, so each cycle carries at most one pulse. Two hysteretic monitors watch digitised samples of the supply and of the reference. While either monitor is in lockout, the gate is held low and the latch is kept clear.

Top module: `cm_pwm_gate`

## Requirements
- R1: While rst_ni is low, gate_o is 0, sup_lock_o and ref_lock_o are both 1, and dis_blank_o is 1 (the oscillator waits in discharge).
- R2: The charge phase lasts max(ramp_len_i,1) clocks and the discharge phase lasts max(dis_len_i,1) clocks. dis_blank_o is 1 throughout discharge, and gate_o is then 0.
- R3: The toggle stage changes state only at a cycle start. gate_o pulses only on alternate cycles, and off_cycle_o is 1 during a blanked cycle. The time between rising edges of gate_o is 2*(Lr+Ld), where Lr and Ld are the effective charge and discharge lengths.
- R4: With trip_i held low and both monitors enabled, each gate_o pulse lasts Lr clocks, so the duty cycle never exceeds 50%.
- R5: If trip_i is sampled high while gate_o is high, gate_o is 0 from the next clock and stays 0 until the next on-cycle start. The pulse period is unchanged.
- R6: A trip at the cycle-start edge wins over the set, so that cycle gives no pulse. A trip strobe during discharge or during an off cycle has no effect on the next pulse, which keeps its full width Lr.
- R7: ramp_len_i and dis_len_i are captured only at a cycle start. A change made in mid-cycle leaves the running pulse at its old width, and the next pulse uses the new width.
- R8: The supply monitor leaves lockout one clock after sup_smp_i > SUP_ON and enters lockout one clock after sup_smp_i < SUP_OFF. A sample equal to either threshold, or a sample between the thresholds, leaves the state unchanged.
- R9: The reference monitor follows the same rule on ref_smp_i, using REF_ON and REF_OFF.
- R10: While either monitor is in lockout, gate_o is 0. After release, no partial pulse appears: the first pulse starts at a cycle start and lasts Lr clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_len_i | input | CNT_W | Charge phase length in clocks (0 is treated as 1) |
| dis_len_i | input | CNT_W | Discharge phase length in clocks (0 is treated as 1) |
| trip_i | input | 1 | Peak-current trip strobe; resets the PWM latch |
| sup_smp_i | input | SMP_W | Supply sample code |
| ref_smp_i | input | SMP_W | Reference sample code |
| gate_o | output | 1 | Gate drive |
| dis_blank_o | output | 1 | Discharge blanking active |
| off_cycle_o | output | 1 | Current cycle is blanked by the toggle stage |
| sup_lock_o | output | 1 | Supply monitor in lockout |
| ref_lock_o | output | 1 | Reference monitor in lockout |

## Verification
The bench builds the block with the low-voltage supply thresholds, SUP_ON = 336 and SUP_OFF = 304, and keeps the default reference thresholds of 144 and 136. On this scale the sample codes step in 25 mV units. The bench then drives samples that sit exactly on each threshold, one code beyond it, and inside the hysteresis band. Short ramp and discharge lengths, including zero, keep a full two-cycle output period to between 4 and 16 clocks. Many periods therefore fit in each scenario, and a mid-cycle length change or a trip can be placed on a chosen phase clock.

// File: rtl/cm_pwm_pkg.sv
package cm_pwm_pkg;
  typedef enum logic {PH_CHG = 1'b0, PH_DIS = 1'b1} osc_phase_e;
endpackage

// File: rtl/cm_pwm_osc.sv
module cm_pwm_osc
  import cm_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ramp_len_i,
  input  logic [CNT_W-1:0] dis_len_i,
  output logic             dis_o,
  output logic             start_o,
  output logic             tog_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  osc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q, ramp_q, dis_q;
  logic [CNT_W-1:0] ramp_eff, dis_eff;
  logic             tog_q;

  assign ramp_eff = (ramp_len_i == '0) ? ONE : ramp_len_i;
  assign dis_eff  = (dis_len_i  == '0) ? ONE : dis_len_i;
  assign start_o  = (phase_q == PH_DIS) && (cnt_q == dis_q - ONE);
  assign dis_o    = (phase_q == PH_DIS);
  assign tog_o    = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DIS;
      cnt_q   <= '0;
      ramp_q  <= ONE;
      dis_q   <= ONE;
      tog_q   <= 1'b1;
    end else if (phase_q == PH_CHG) begin
      if (cnt_q == ramp_q - ONE) begin
        phase_q <= PH_DIS;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else if (start_o) begin
      // lengths captured only here: no runt cycles
      phase_q <= PH_CHG;
      cnt_q   <= '0;
      ramp_q  <= ramp_eff;
      dis_q   <= dis_eff;
      tog_q   <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  AST_DIS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DIS) |-> (cnt_q < dis_q)); // R2
  AST_TOG_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> $stable(tog_q)); // R3
  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> ($stable(ramp_q) && $stable(dis_q))); // R7
endmodule

// File: rtl/cm_pwm_uvlo.sv
module cm_pwm_uvlo #(
  parameter int SMP_W  = 10,
  parameter int ON_TH  = 640,
  parameter int OFF_TH = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  output logic             ok_o
);
  localparam logic [SMP_W-1:0] ON_C  = SMP_W'(ON_TH);
  localparam logic [SMP_W-1:0] OFF_C = SMP_W'(OFF_TH);

  logic ok_q;
  assign ok_o = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ok_q <= 1'b0;
    else if (!ok_q && smp_i > ON_C)  ok_q <= 1'b1;
    else if (ok_q && smp_i < OFF_C)  ok_q <= 1'b0;
  end

  AST_HYST_KEEP_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && smp_i >= OFF_C) |=> ok_q); // R8 R9
  AST_HYST_KEEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_q && smp_i <= ON_C) |=> !ok_q); // R8 R9
endmodule

// File: rtl/cm_pwm_gate.sv
module cm_pwm_gate #(
  parameter int CNT_W   = 8,
  parameter int SMP_W   = 10,
  parameter int SUP_ON  = 640,
  parameter int SUP_OFF = 400,
  parameter int REF_ON  = 144,
  parameter int REF_OFF = 136
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ramp_len_i,
  input  logic [CNT_W-1:0] dis_len_i,
  input  logic             trip_i,
  input  logic [SMP_W-1:0] sup_smp_i,
  input  logic [SMP_W-1:0] ref_smp_i,
  output logic             gate_o,
  output logic             dis_blank_o,
  output logic             off_cycle_o,
  output logic             sup_lock_o,
  output logic             ref_lock_o
);
  logic dis, start, tog, sup_ok, ref_ok, run_ok, latch_q;

  cm_pwm_osc #(.CNT_W(CNT_W)) u_osc (
    .clk_i, .rst_ni, .ramp_len_i, .dis_len_i,
    .dis_o(dis), .start_o(start), .tog_o(tog)
  );

  cm_pwm_uvlo #(.SMP_W(SMP_W), .ON_TH(SUP_ON), .OFF_TH(SUP_OFF)) u_sup (
    .clk_i, .rst_ni, .smp_i(sup_smp_i), .ok_o(sup_ok)
  );

  cm_pwm_uvlo #(.SMP_W(SMP_W), .ON_TH(REF_ON), .OFF_TH(REF_OFF)) u_ref (
    .clk_i, .rst_ni, .smp_i(ref_smp_i), .ok_o(ref_ok)
  );

  assign run_ok = sup_ok & ref_ok;

  // reset-dominant latch; lockout also keeps it clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 latch_q <= 1'b0;
    else if (trip_i || !run_ok)  latch_q <= 1'b0;
    else if (start)              latch_q <= 1'b1;
  end

  assign gate_o      = ~(dis | tog | ~latch_q | ~run_ok);
  assign dis_blank_o = dis;
  assign off_cycle_o = tog;
  assign sup_lock_o  = ~sup_ok;
  assign ref_lock_o  = ~ref_ok;

  AST_DIS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |-> !gate_o); // R2
  AST_TRIP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> !gate_o); // R5
  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(start)); // R6
  AST_LOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_ok || !ref_ok) |-> !gate_o); // R10
endmodule

// File: tb/cm_pwm_gate_test.sv
module cm_pwm_gate_test;
  localparam int CW = 8;
  localparam int SW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, trip, gate, dblank, offc, slock, rlock;
  logic [CW-1:0] ramp, dlen;
  logic [SW-1:0] sup, refv;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  cm_pwm_gate #(.CNT_W(CW), .SMP_W(SW), .SUP_ON(336), .SUP_OFF(304),
                .REF_ON(144), .REF_OFF(136)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ramp_len_i(ramp), .dis_len_i(dlen),
    .trip_i(trip), .sup_smp_i(sup), .ref_smp_i(refv), .gate_o(gate),
    .dis_blank_o(dblank), .off_cycle_o(offc), .sup_lock_o(slock), .ref_lock_o(rlock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves at the sample where gate_o next rises
  task automatic meas(output int w, output int p);
    int t;
    t = 0; w = -1; p = -1;
    while (gate && t < 400) begin step(1); t++; end
    while (!gate && t < 400) begin step(1); t++; end
    if (t >= 400) return;
    w = 0;
    while (gate && t < 400) begin w++; step(1); t++; end
    p = w;
    while (!gate && t < 400) begin p++; step(1); t++; end
  endtask

  task automatic high_run(output int w);
    w = 0;
    while (gate && w < 400) begin w++; step(1); end
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(1); if (gate) c++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; trip = 1'b0; ramp = 8'd6; dlen = 8'd2; sup = 10'd500; refv = 10'd200;
    step(3);
    chk("R1 gate", int'(gate), 0);
    chk("R1 sup_lock", int'(slock), 1);
    chk("R1 ref_lock", int'(rlock), 1);
    chk("R1 dis_blank", int'(dblank), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    int w, p;
    meas(w, p);
    meas(w, p);
    chk("R4 width", w, 6);
    chk("R3 period", p, 16);
    step(6);
    chk("R2 dis_blank", int'(dblank), 1);
    chk("R2 gate in discharge", int'(gate), 0);
    step(2);
    chk("R3 off_cycle", int'(offc), 1);
    chk("R3 gate in off cycle", int'(gate), 0);
  endtask

  task automatic t_lengths();
    int w, p;
    ramp = 8'd3; dlen = 8'd5;
    meas(w, p); meas(w, p);
    chk("R4 width 3/5", w, 3);
    chk("R3 period 3/5", p, 16);
    chk("R4 duty <= 50%", int'(2 * w <= p), 1);
    ramp = 8'd0; dlen = 8'd0;
    meas(w, p); meas(w, p);
    chk("R2 zero ramp width", w, 1);
    chk("R2 zero lengths period", p, 4);
    ramp = 8'd6; dlen = 8'd2;
    meas(w, p); meas(w, p);
  endtask

  task automatic t_len_change();
    int w, p;
    meas(w, p);
    ramp = 8'd3;
    high_run(w);
    chk("R7 running pulse keeps old width", w, 6);
    meas(w, p);
    chk("R7 next pulse new width", w, 3);
    chk("R7 new period", p, 10);
    ramp = 8'd6;
    meas(w, p); meas(w, p);
  endtask

  task automatic t_trip();
    int w, p, c;
    meas(w, p);
    trip = 1'b1; step(1); trip = 1'b0;
    chk("R5 gate low after trip", int'(gate), 0);
    c = 1;
    while (!gate && c < 100) begin c++; step(1); end
    chk("R5 period kept after trip", c, 16);
  endtask

  task automatic t_trip_hold();
    int w, p, c;
    trip = 1'b1;
    count_high(40, c);
    chk("R6 held trip blocks pulses", c, 0);
    trip = 1'b0;
    meas(w, p);
    chk("R6 width after trip release", w, 6);
  endtask

  task automatic t_trip_off();
    int w, p;
    meas(w, p);
    high_run(w);
    trip = 1'b1; step(1); trip = 1'b0; // discharge
    step(4);
    trip = 1'b1; step(1); trip = 1'b0; // off cycle
    meas(w, p);
    chk("R6 trip in blanking ignored", w, 6);
  endtask

  task automatic t_sup();
    int w, p, c;
    sup = 10'd320; step(3);
    chk("R8 between thresholds stays on", int'(slock), 0);
    sup = 10'd304; step(3);
    chk("R8 equal off threshold stays on", int'(slock), 0);
    sup = 10'd303; step(1);
    chk("R8 below off locks", int'(slock), 1);
    chk("R10 gate low in supply lock", int'(gate), 0);
    sup = 10'd336;
    count_high(40, c);
    chk("R10 no pulse in supply lock", c, 0);
    chk("R8 equal on threshold stays locked", int'(slock), 1);
    sup = 10'd337; step(1);
    chk("R8 above on unlocks", int'(slock), 0);
    meas(w, p);
    chk("R10 full first pulse after supply unlock", w, 6);
  endtask

  task automatic t_ref();
    int w, p, c;
    refv = 10'd136; step(3);
    chk("R9 equal off stays on", int'(rlock), 0);
    refv = 10'd135; step(1);
    chk("R9 below off locks", int'(rlock), 1);
    refv = 10'd144;
    count_high(40, c);
    chk("R10 no pulse in reference lock", c, 0);
    chk("R9 equal on stays locked", int'(rlock), 1);
    refv = 10'd145; step(1);
    chk("R9 above on unlocks", int'(rlock), 0);
    meas(w, p);
    chk("R10 full first pulse after reference unlock", w, 6);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lengths();
    t_len_change();
    t_trip();
    t_trip_hold();
    t_trip_off();
    t_sup();
    t_ref();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule